// File: doc/BRIEF.md
# Serial Character Transmitter with Clear-to-Send Gating

This block sends bytes as asynchronous serial characters on a single output line. A byte written through the data port lands in a one-entry holding buffer. On a baud tick it moves into a shift register, and a character engine sends it as a start bit, eight data bits, an optional parity bit and a stop bit. Every bit lasts exactly one baud-tick interval. Baud-rate generation lies outside the block, which only receives a one-cycle tick.

A clear-to-send input, active low, can pause the line. It is only honoured when its enable is set, and it only takes effect between characters, so a character that has started always finishes. Two sticky status flags report progress. The buffer-free flag sets when the held byte moves into the shifter. The line-done flag sets when a character ends and no byte is waiting. Software clears each flag. Each flag has an interrupt enable, and a global enable gates the combined request.

Top module: `sertx_top`

## Requirements
- R1: After reset, `txd` is 1, `tbe_flag` is 1, `eot_flag` is 0 and `irq` is 0. `txd` stays 1 whenever no character is being sent.
- R2: A character is a 0 start bit, then the eight data bits starting with bit 0, then a 1 stop bit. Each bit holds for one baud-tick interval. A character begins at the first `baud_tick` on which the holding buffer has a byte and sending is allowed.
- R3: When `par_en` is 1, a parity bit follows the data bits. With `par_odd` = 0 it makes the count of ones in data plus parity even. With `par_odd` = 1 it makes that count odd. When `par_en` is 0, no parity bit is sent.
- R4: A write while the holding buffer is full is ignored. The held byte is kept and sent unchanged, and the ignored byte never appears on `txd`.
- R5: If a byte is waiting and sending is allowed when a stop bit ends, the next start bit begins on that same tick. Character starts are then exactly one character time apart.
- R6: With `cts_en` = 1 and `cts_n` = 1, no new character starts. The waiting byte stays in the buffer, so `tbe_flag` does not set, until `cts_n` returns to 0.
- R7: Raising `cts_n` while a character is being sent does not cut that character short. Only the next character is held back.
- R8: With `cts_en` = 0, `cts_n` has no effect on sending.
- R9: `tbe_flag` sets when the held byte moves into the shifter and stays set until a cycle with `flag_clr[0]` = 1. A new setting event wins over a clear in the same cycle.
- R10: `eot_flag` sets when a stop bit ends and the holding buffer is empty. It stays set until `flag_clr[1]` = 1. It does not set while a byte is still waiting.
- R11: `irq` = `irq_glb_en` AND ((`tbe_flag` AND `irq_en[0]`) OR (`eot_flag` AND `irq_en[1]`)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | One-cycle pulse that marks each bit boundary |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to send |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| cts_en | input | 1 | Honour `cts_n` when 1 |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| flag_clr | input | 2 | Clear strobes: bit 0 for `tbe_flag`, bit 1 for `eot_flag` |
| irq_en | input | 2 | Per-flag interrupt enables, same bit order as `flag_clr` |
| irq_glb_en | input | 1 | Global interrupt enable |
| txd | output | 1 | Serial output line |
| tbe_flag | output | 1 | Sticky flag: holding buffer has become free |
| eot_flag | output | 1 | Sticky flag: line has gone idle with nothing waiting |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets these corner cases:

- **Write into a full buffer.** A design that let this write overwrite the held byte would send the wrong data, and the scoreboard would see a mismatch. One that queued the write would send an extra character.
- **Clear-to-send raised mid-character.** A design that stopped at once would produce a cut-off frame. One that did not hold afterwards would send the waiting byte too early, and the frame count would show it.
- **Back-to-back characters.** Character starts must be exactly one character time apart. An extra idle bit between them shows up as a wrong spacing.
- **Line-done flag with a byte still held.** This flag must stay clear while the byte waits. A design that set it whenever a stop bit ended would be caught.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DATA_W  = 8;
    localparam int FRAME_W = DATA_W + 3;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int NFLAG   = 2;

    localparam int FLG_TBE = 0;
    localparam int FLG_EOT = 1;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } hold_entry_t;

    typedef struct packed {
        logic              par_en;
        logic              par_odd;
    } frame_cfg_t;

    function automatic logic parity_of(input logic [DATA_W-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    function automatic logic [FRAME_W-1:0] build_frame(input logic [DATA_W-1:0] d,
                                                       input frame_cfg_t cfg);
        logic pbit;
        pbit = cfg.par_en ? parity_of(d, cfg.par_odd) : 1'b1;
        return {1'b1, pbit, d, 1'b0};
    endfunction

endpackage

// File: rtl/sertx_sync.sv
module sertx_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/sertx_holdbuf.sv
module sertx_holdbuf
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pop,
    output hold_entry_t       entry
);
    always_ff @(posedge clk) begin
        if (rst) begin
            entry <= '0;
        end else if (pop) begin
            entry.valid <= 1'b0;
        end else if (wr_en && !entry.valid) begin
            entry.valid <= 1'b1;
            entry.data  <= wr_data;
        end
    end

    // R4: a write into a full buffer leaves the held byte untouched
    p_full_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (entry.valid && wr_en && !pop) |=> (entry.valid && $stable(entry.data)));
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        allow,
    input  hold_entry_t entry,
    input  frame_cfg_t  cfg,
    output logic        pop,
    output logic        busy,
    output logic        eot_set,
    output logic        txd
);
    tx_state_e          state;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   remain;
    logic               end_tick;

    assign end_tick = tick && (state == TX_SEND) && (remain == CNT_W'(1));
    assign pop      = tick && entry.valid && allow && ((state == TX_IDLE) || (remain == CNT_W'(1)));
    assign eot_set  = end_tick && !entry.valid;
    assign busy     = (state == TX_SEND);
    assign txd      = busy ? frame[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= TX_IDLE;
            frame  <= '1;
            remain <= '0;
        end else if (pop) begin
            state  <= TX_SEND;
            frame  <= build_frame(entry.data, cfg);
            remain <= cfg.par_en ? CNT_W'(FRAME_W) : CNT_W'(FRAME_W - 1);
        end else if (end_tick) begin
            state  <= TX_IDLE;
            frame  <= '1;
            remain <= '0;
        end else if (tick && state == TX_SEND) begin
            frame  <= {1'b1, frame[FRAME_W-1:1]};
            remain <= remain - CNT_W'(1);
        end
    end

    // R2: a bit level only moves on a baud tick
    p_bit_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> $stable(txd));

    // R7: a started character runs to its stop bit
    p_midchar_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !end_tick) |=> busy);

    // R1: the line is high whenever nothing is being sent
    p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy && !pop) |=> txd);
endmodule

// File: rtl/sertx_flags.sv
module sertx_flags #(
    parameter int              N       = 2,
    parameter logic [N-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] en,
    input  logic         glb_en,
    output logic [N-1:0] flags,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)         flags[i] <= RST_VAL[i];
            else if (set[i]) flags[i] <= 1'b1;
            else if (clr[i]) flags[i] <= 1'b0;
        end

        // R9 and R10: flags are sticky until cleared
        p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
            (flags[i] && !clr[i]) |=> flags[i]);

        // R10: a clear without a setting event takes effect
        p_flag_clear_r10: assert property (@(posedge clk) disable iff (rst)
            (clr[i] && !set[i]) |=> !flags[i]);
    end

    assign irq = glb_en && |(flags & en);
endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cts_n,
    input  logic              cts_en,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [NFLAG-1:0]  flag_clr,
    input  logic [NFLAG-1:0]  irq_en,
    input  logic              irq_glb_en,
    output logic              txd,
    output logic              tbe_flag,
    output logic              eot_flag,
    output logic              irq
);
    logic        cts_n_s;
    logic        allow;
    logic        pop;
    logic        busy;
    logic        eot_set;
    hold_entry_t entry;
    frame_cfg_t  cfg;
    logic [NFLAG-1:0] flag_set;
    logic [NFLAG-1:0] flag_vec;

    assign cfg   = '{par_en: par_en, par_odd: par_odd};
    assign allow = !cts_en || !cts_n_s;

    sertx_sync #(.STAGES(2), .RST_VAL(1'b1)) u_cts_sync (
        .clk (clk),
        .rst (rst),
        .din (cts_n),
        .dout(cts_n_s)
    );

    sertx_holdbuf u_hold (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .pop    (pop),
        .entry  (entry)
    );

    sertx_shifter u_shift (
        .clk    (clk),
        .rst    (rst),
        .tick   (baud_tick),
        .allow  (allow),
        .entry  (entry),
        .cfg    (cfg),
        .pop    (pop),
        .busy   (busy),
        .eot_set(eot_set),
        .txd    (txd)
    );

    always_comb begin
        flag_set          = '0;
        flag_set[FLG_TBE] = pop;
        flag_set[FLG_EOT] = eot_set;
    end

    sertx_flags #(.N(NFLAG), .RST_VAL(NFLAG'(1) << FLG_TBE)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .set   (flag_set),
        .clr   (flag_clr),
        .en    (irq_en),
        .glb_en(irq_glb_en),
        .flags (flag_vec),
        .irq   (irq)
    );

    assign tbe_flag = flag_vec[FLG_TBE];
    assign eot_flag = flag_vec[FLG_EOT];

    // R6: while clear-to-send blocks, an idle shifter stays idle
    p_cts_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!busy && !allow) |=> !busy);

    // R10: line-done never sets while a byte is waiting
    p_eot_pending_r10: assert property (@(posedge clk) disable iff (rst)
        (entry.valid && !eot_flag) |=> !eot_flag);
endmodule

// File: tb/sertx_top_test.sv
module sertx_top_test;
    localparam int CLK_P    = 10;
    localparam int TICK_DIV = 4;
    localparam int CHAR10   = 10 * TICK_DIV;

    typedef struct {
        logic [7:0] data;
        logic       pe;
        logic       po;
        string      tag;
    } exp_t;

    logic clk = 0, rst = 1, baud_tick = 0, wr_en = 0;
    logic [7:0] wr_data = 0;
    logic cts_n = 0, cts_en = 0, par_en = 0, par_odd = 0, irq_glb_en = 0;
    logic [1:0] flag_clr = 0, irq_en = 0;
    logic txd, tbe_flag, eot_flag, irq;

    int n_chk = 0, n_bad = 0, frames = 0, cyc = 0;
    int start_prev = 0, start_last = 0;
    exp_t q[$];

    sertx_top uut (.*);

    always #(CLK_P/2) clk = ~clk;

    int tdiv = 0;
    always @(negedge clk) begin
        cyc++;
        tdiv = (tdiv + 1) % TICK_DIV;
        baud_tick <= (tdiv == 0) && !rst;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor / scoreboard
    bit in_frame = 0, prev_txd = 1;
    int k = 0, nb = 0;
    logic [10:0] bits;
    exp_t cur;
    always @(negedge clk) begin
        if (rst) begin
            in_frame = 0; prev_txd = 1;
        end else begin
            if (!in_frame && prev_txd && !txd) begin
                in_frame = 1; k = 0; bits = '1;
                start_prev = start_last; start_last = cyc;
                if (q.size() == 0) begin
                    chk(0, "R4 unexpected frame", 0, 1);
                    cur = '{8'h00, 1'b0, 1'b0, "R4"};
                end else cur = q.pop_front();
                nb = cur.pe ? 11 : 10;
            end
            if (in_frame) begin
                k++;
                if (k >= 3 && ((k - 3) % 4) == 0) begin
                    bits[(k-3)/4] = txd;
                    if ((k - 3) / 4 == nb - 1) begin
                        logic [10:0] want;
                        want = cur.pe ? {1'b1, (^cur.data) ^ cur.po, cur.data, 1'b0}
                                      : {2'b11, cur.data, 1'b0};
                        chk(bits == want, {cur.tag, " frame"}, int'(bits), int'(want));
                        frames++;
                        in_frame = 0;
                    end
                end
            end
            prev_txd = txd;
        end
    end

    task automatic write_byte(input logic [7:0] d, input bit accept, input string tag);
        @(negedge clk);
        wr_en = 1; wr_data = d;
        if (accept) q.push_back('{d, par_en, par_odd, tag});
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic clear_flags();
        @(negedge clk); flag_clr = 2'b11;
        @(negedge clk); flag_clr = 2'b00;
    endtask

    task automatic wait_eot(input string tag);
        int t;
        t = 0;
        while (!eot_flag && t < 3000) begin @(negedge clk); t++; end
        chk(eot_flag, tag, eot_flag, 1);
        repeat (4) @(negedge clk);
        chk(q.size() == 0, {tag, " all sent"}, q.size(), 0);
    endtask

    task automatic wait_tbe();
        int t;
        t = 0;
        while (!tbe_flag && t < 3000) begin @(negedge clk); t++; end
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int f0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(txd == 1,      "R1 txd",  txd, 1);
        chk(tbe_flag == 1, "R1 tbe",  tbe_flag, 1);
        chk(eot_flag == 0, "R1 eot",  eot_flag, 0);
        chk(irq == 0,      "R1 irq",  irq, 0);

        // R2 plain frames
        clear_flags();
        write_byte(8'hA5, 1, "R2");
        wait_eot("R2 eot");
        clear_flags();
        write_byte(8'h01, 1, "R2");
        wait_eot("R2 eot");

        // R3 parity variants
        par_en = 1; par_odd = 0;
        clear_flags(); write_byte(8'h37, 1, "R3 even"); wait_eot("R3 eot");
        par_odd = 1;
        clear_flags(); write_byte(8'h37, 1, "R3 odd");  wait_eot("R3 eot");
        clear_flags(); write_byte(8'h00, 1, "R3 odd0"); wait_eot("R3 eot");
        par_en = 0; par_odd = 0;

        // R4 / R5 back-to-back and ignored write
        clear_flags();
        f0 = frames;
        write_byte(8'h11, 1, "R5");
        wait_tbe();
        write_byte(8'h22, 1, "R4 held");
        write_byte(8'h33, 0, "R4");
        // R10: byte still waiting, eot must stay clear
        repeat (TICK_DIV * 6) @(negedge clk);
        chk(eot_flag == 0, "R10 pending", eot_flag, 0);
        wait_eot("R5 eot");
        chk(frames - f0 == 2, "R4 frame count", frames - f0, 2);
        chk(start_last - start_prev == CHAR10, "R5 spacing", start_last - start_prev, CHAR10);

        // R6 hold before start
        cts_en = 1; cts_n = 1;
        repeat (4) @(negedge clk);
        clear_flags();
        f0 = frames;
        write_byte(8'h5A, 1, "R6");
        repeat (TICK_DIV * 20) @(negedge clk);
        chk(frames == f0 && txd == 1, "R6 held line", frames - f0, 0);
        chk(tbe_flag == 0, "R6 byte kept", tbe_flag, 0);
        cts_n = 0;
        wait_eot("R6 eot");

        // R7 raise mid-character
        clear_flags();
        f0 = frames;
        write_byte(8'hC3, 1, "R7");
        wait_tbe();
        write_byte(8'h3C, 1, "R7 next");
        repeat (TICK_DIV * 3) @(negedge clk);
        cts_n = 1;
        repeat (TICK_DIV * 30) @(negedge clk);
        chk(frames - f0 == 1, "R7 one frame", frames - f0, 1);
        chk(eot_flag == 0, "R10 held byte", eot_flag, 0);
        cts_n = 0;
        wait_eot("R7 eot");

        // R8 enable off ignores cts_n
        cts_en = 0; cts_n = 1;
        clear_flags();
        write_byte(8'h96, 1, "R8");
        wait_eot("R8 eot");
        cts_n = 0;

        // R9 / R10 clear and sticky
        clear_flags();
        @(negedge clk);
        chk(tbe_flag == 0, "R9 cleared", tbe_flag, 0);
        chk(eot_flag == 0, "R10 cleared", eot_flag, 0);
        write_byte(8'h7E, 1, "R9");
        wait_tbe();
        chk(tbe_flag == 1, "R9 set on move", tbe_flag, 1);
        wait_eot("R10 eot");
        repeat (8) @(negedge clk);
        chk(tbe_flag == 1, "R9 sticky", tbe_flag, 1);

        // R11 interrupt gating (both flags set)
        irq_en = 2'b00; irq_glb_en = 1; @(negedge clk);
        chk(irq == 0, "R11 no enables", irq, 0);
        irq_en = 2'b01; @(negedge clk);
        chk(irq == 1, "R11 tbe en", irq, 1);
        irq_glb_en = 0; @(negedge clk);
        chk(irq == 0, "R11 global off", irq, 0);
        irq_glb_en = 1; irq_en = 2'b10;
        @(negedge clk); flag_clr = 2'b10;
        @(negedge clk); flag_clr = 2'b00;
        chk(irq == 0, "R11 eot cleared", irq, 0);
        irq_en = 2'b01; @(negedge clk);
        chk(irq == 1, "R11 tbe remains", irq, 1);

        repeat (10) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule